// File: doc/BRIEF.md
# Time-Decimated Constant Matrix-Vector Unit

This block forms the product Y = C·X of a constant N×N matrix C and an input vector X, producing one element of Y per clock cycle rather than all N at once. Each input column owns a single multiplier whose constant is chosen from a bank of N design-time values by the current row number. The N column products of a cycle are reduced by an adder tree to one output element, so the hardware cost grows with N rather than with N².

A one-cycle start pulse captures the whole input vector. The row sequencer then steps through rows 0 to N−1 on consecutive cycles. Each result leaves the adder tree, which can be built registered at every level or as a single combinational stage, together with a valid flag and its row number. A one-cycle done pulse follows the last row. The block accepts a new vector only after done.

Top module: `cmv_unit`

## Requirements
- R1: While reset (rstN low) is held, yValid, done and yOut are all zero.
- R2: A start pulse taken while idle captures xIn, where element j occupies bits [8j+7:8j] as an 8-bit two's-complement value. Later changes on xIn have no effect on the results of that vector.
- R3: After an accepted start sampled at clock edge E0, row r (0..N−1) is presented on yOut with yValid high and yRow = r during the cycle after edge E(r+LAT). Rows come in ascending order on consecutive cycles. LAT is log2(N) when the tree is registered per level (TREE_REG=1, the default; LAT=2 for N=4) and 1 otherwise.
- R4: yOut is the exact two's-complement sum over j of c(r,j)·x_j, 16 + log2(N) bits wide (18 for N=4).
- R5: The constant for row r and column j is c(r,j) = ((r·N + j)·45 + 3) mod 256, read as an 8-bit two's-complement number.
- R6: done is high for exactly one cycle, the cycle after the last row's output. The block is idle again from that cycle.
- R7: A start pulse from the accepting edge until done is ignored. It neither restarts the rows nor recaptures xIn.
- R8: yValid is low in every cycle other than the N row cycles of an accepted vector, including the done cycle.
- R9: Input vectors at the extremes (all elements −128, all +127, mixed signs) give exact results with no wrap.
- R10: Asserting reset during a vector abandons it. No further rows and no done appear until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to capture xIn and run a vector |
| xIn | input | 32 | Packed input vector, N elements of 8 bits |
| yOut | output | 18 | Current output element of Y |
| yValid | output | 1 | yOut holds a valid row |
| yRow | output | 2 | Row index of yOut |
| done | output | 1 | One-cycle pulse after the last row |

## Verification
Every result is due at a fixed cycle counted from the edge that accepts start: row r appears in the cycle after edge r+LAT and done in the cycle after edge N+LAT. The bench drives on falling edges and checks yValid, yRow, yOut and done at the falling edge of every cycle from the start edge through one cycle past done. Each sample is compared with the value due at that cycle count, so an early, late, missing or extra row is reported. The reference products come from the constant formula of R5 evaluated in the bench. An ignored start is injected in the middle of a run with a different xIn, and the remaining rows must still match the first vector.

// File: rtl/cmv_pkg.sv
package cmv_pkg;

  localparam int COEF_W = 8;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_RUN   = 2'd1,
    S_DRAIN = 2'd2
  } cmvState_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadX;   // capture the input vector this edge
    logic issue;   // current row enters the adder tree
  } cmvStrobe_t;

  // Design-time constant for row r, column c of an n-wide matrix
  function automatic logic [COEF_W-1:0] coefAt(input int r, input int c, input int n);
    int k;
    k = r * n + c;
    return COEF_W'((k * 45 + 3) % 256);
  endfunction

endpackage

// File: rtl/cmv_ctrl.sv
module cmv_ctrl
  import cmv_pkg::*;
#(
  parameter int N   = 4,
  parameter int LAT = 2,
  localparam int RW = $clog2(N),
  localparam int KW = $clog2(LAT + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  output cmvStrobe_t    strb,
  output logic [RW-1:0] row,
  output logic          done
);

  cmvState_t     state;
  logic [KW-1:0] drainCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      row      <= '0;
      drainCnt <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            state <= S_RUN;
            row   <= '0;
          end
        end
        S_RUN: begin
          if (row == RW'(N - 1)) begin
            state    <= S_DRAIN;
            drainCnt <= '0;
          end else begin
            row <= row + 1'b1;
          end
        end
        S_DRAIN: begin
          if (drainCnt == KW'(LAT - 1)) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else begin
            drainCnt <= drainCnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.loadX = (state == S_IDLE) && start;
    strb.issue = (state == S_RUN);
  end

endmodule

// File: rtl/cmv_datapath.sv
module cmv_datapath
  import cmv_pkg::*;
#(
  parameter int N        = 4,
  parameter int DW       = 8,
  parameter bit TREE_REG = 1'b1,
  localparam int RW  = $clog2(N),
  localparam int PW  = DW + COEF_W,
  localparam int OW  = PW + RW,
  localparam int LAT = TREE_REG ? RW : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  cmvStrobe_t    strb,
  input  logic [RW-1:0] row,
  input  logic [N*DW-1:0] xIn,
  output logic [OW-1:0] yOut,
  output logic          yValid,
  output logic [RW-1:0] yRow
);

  // All N constants of one column, row 0 in the low bits
  function automatic logic [N*COEF_W-1:0] colBank(input int c);
    logic [N*COEF_W-1:0] b;
    b = '0;
    for (int r = 0; r < N; r++) b[r*COEF_W +: COEF_W] = coefAt(r, c, N);
    return b;
  endfunction

  logic signed [DW-1:0] xReg [N];
  logic signed [OW-1:0] leaf [N];
  logic                 vPipe [LAT];
  logic [RW-1:0]        rPipe [LAT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int j = 0; j < N; j++) xReg[j] <= '0;
    end else if (strb.loadX) begin
      for (int j = 0; j < N; j++) xReg[j] <= xIn[j*DW +: DW];
    end
  end

  // One reconfigurable constant multiplier per column
  for (genvar gc = 0; gc < N; gc++) begin : g_col
    localparam logic [N*COEF_W-1:0] BANK = colBank(gc);
    logic signed [COEF_W-1:0] coef;
    logic signed [PW-1:0]     prod;
    assign coef     = $signed(BANK[row*COEF_W +: COEF_W]);
    assign prod     = xReg[gc] * coef;
    assign leaf[gc] = {{RW{prod[PW-1]}}, prod};
  end

  // Adder tree in heap order: node i sums nodes 2i+1 and 2i+2
  if (TREE_REG) begin : g_treeReg
    logic signed [OW-1:0] t    [2*N-1];
    logic signed [OW-1:0] sumQ [N-1];
    always_comb begin
      for (int k = 0; k < N; k++) t[N-1+k] = leaf[k];
      for (int i = 0; i < N - 1; i++) t[i] = sumQ[i];
    end
    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int i = 0; i < N - 1; i++) sumQ[i] <= '0;
      end else begin
        for (int i = 0; i < N - 1; i++) sumQ[i] <= t[2*i+1] + t[2*i+2];
      end
    end
    assign yOut = sumQ[0];
  end else begin : g_treeComb
    logic signed [OW-1:0] t [2*N-1];
    logic signed [OW-1:0] yQ;
    always_comb begin
      for (int k = 0; k < N; k++) t[N-1+k] = leaf[k];
      for (int i = N - 2; i >= 0; i--) t[i] = t[2*i+1] + t[2*i+2];
    end
    always_ff @(posedge clk) begin
      if (!rstN) yQ <= '0;
      else       yQ <= t[0];
    end
    assign yOut = yQ;
  end

  // Valid and row index travel alongside the tree
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < LAT; s++) begin
        vPipe[s] <= 1'b0;
        rPipe[s] <= '0;
      end
    end else begin
      vPipe[0] <= strb.issue;
      rPipe[0] <= row;
      for (int s = 1; s < LAT; s++) begin
        vPipe[s] <= vPipe[s-1];
        rPipe[s] <= rPipe[s-1];
      end
    end
  end

  assign yValid = vPipe[LAT-1];
  assign yRow   = rPipe[LAT-1];

endmodule

// File: rtl/cmv_unit.sv
module cmv_unit
  import cmv_pkg::*;
#(
  parameter int N        = 4,
  parameter int DW       = 8,
  parameter bit TREE_REG = 1'b1,
  localparam int RW  = $clog2(N),
  localparam int OW  = DW + COEF_W + RW,
  localparam int LAT = TREE_REG ? RW : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [N*DW-1:0] xIn,
  output logic [OW-1:0]   yOut,
  output logic            yValid,
  output logic [RW-1:0]   yRow,
  output logic            done
);

  cmvStrobe_t    strb;
  logic [RW-1:0] rowSel;

  cmv_ctrl #(.N(N), .LAT(LAT)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .strb  (strb),
    .row   (rowSel),
    .done  (done)
  );

  cmv_datapath #(.N(N), .DW(DW), .TREE_REG(TREE_REG)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .row    (rowSel),
    .xIn    (xIn),
    .yOut   (yOut),
    .yValid (yValid),
    .yRow   (yRow)
  );

endmodule

// File: rtl/cmv_checker.sv
module cmv_checker #(
  parameter int N = 4,
  localparam int RW = $clog2(N)
) (
  input logic          clk,
  input logic          rstN,
  input logic          yValid,
  input logic [RW-1:0] yRow,
  input logic          done
);

  AST_ROW_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (yValid && yRow != RW'(N - 1)) |=> (yValid && yRow == RW'($past(yRow) + 1'b1))); // R3

  AST_FIRST_ROW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(yValid) |-> (yRow == '0)); // R3

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (yValid && yRow == RW'(N - 1)) |=> done); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R6

  AST_QUIET_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !yValid); // R8

endmodule

bind cmv_unit cmv_checker #(.N(N)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .yValid (yValid),
  .yRow   (yRow),
  .done   (done)
);

// File: tb/cmv_unit_test.sv
module cmv_unit_test;

  localparam int N   = 4;
  localparam int DW  = 8;
  localparam int RW  = 2;
  localparam int OW  = 18;
  localparam int LAT = 2;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            start = 1'b0;
  logic [N*DW-1:0] xIn = '0;
  logic [OW-1:0]   yOut;
  logic            yValid;
  logic [RW-1:0]   yRow;
  logic            done;

  int errors = 0;
  int checks = 0;

  cmv_unit uut (
    .clk(clk), .rstN(rstN), .start(start), .xIn(xIn),
    .yOut(yOut), .yValid(yValid), .yRow(yRow), .done(done)
  );

  always #4 clk = ~clk;

  // Stimulus table: zero, extremes, mixed signs, small values
  localparam logic [31:0] VECS [8] = '{
    32'h00000000, 32'h7F7F7F7F, 32'h80808080, 32'h7F807F80,
    32'h807F807F, 32'h01020304, 32'hFFFE0510, 32'h3CA55AC3
  };

  // R5 constant formula, written from the requirement
  function automatic longint coefRef(input int r, input int c);
    int v;
    v = ((r * N + c) * 45 + 3) % 256;
    return (v > 127) ? longint'(v - 256) : longint'(v);
  endfunction

  function automatic longint rowRef(input logic [31:0] xv, input int r);
    longint s;
    s = 0;
    for (int j = 0; j < N; j++) s += coefRef(r, j) * longint'($signed(xv[j*8 +: 8]));
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Run one vector, checking every cycle from the accepting edge through
  // one cycle past done. injectAt>0 pulses start with xAlt at that cycle.
  task automatic runVec(input logic [31:0] xv, input int injectAt,
                        input logic [31:0] xAlt, input string req);
    @(negedge clk);
    xIn   = xv;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(yValid == 1'b0, "R8", "valid at accept", yValid, 0);
    for (int c = 1; c <= N + LAT + 1; c++) begin
      if (c == injectAt) begin
        xIn   = xAlt;
        start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      if (c >= LAT && c < LAT + N) begin
        check(yValid == 1'b1, "R3", "valid in row cycle", yValid, 1);
        check(int'(yRow) == c - LAT, "R3", "row index", yRow, c - LAT);
        check(longint'($signed(yOut)) == rowRef(xv, c - LAT), req, "row value",
              $signed(yOut), rowRef(xv, c - LAT));
      end else begin
        check(yValid == 1'b0, "R8", "valid outside rows", yValid, 0);
      end
      check(done == (c == N + LAT), "R6", "done timing", done, (c == N + LAT));
    end
  endtask

  initial begin
    #1500000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(yValid == 1'b0, "R1", "valid in reset", yValid, 0);
    check(done == 1'b0, "R1", "done in reset", done, 0);
    check(yOut == '0, "R1", "yOut in reset", yOut, 0);
    rstN = 1'b1;

    // R4, R9: table walk (extremes in entries 1..4)
    for (int v = 0; v < 8; v++) runVec(VECS[v], 0, '0, (v >= 1 && v <= 4) ? "R9" : "R4");

    // R4: pseudo-random vectors
    for (int v = 0; v < 6; v++) runVec($urandom(), 0, '0, "R4");

    // R5: single-element vectors expose each column constant
    for (int j = 0; j < N; j++) runVec(32'h1 << (8 * j), 0, '0, "R5");

    // R7 and R2: start with a different xIn mid-run is ignored
    runVec(32'h11223344, 2, 32'h7F7F7F7F, "R7");
    runVec(32'h80017F05, 5, 32'h00000000, "R2");
    runVec(32'h80017F05, 6, 32'h12345678, "R7");

    // Back-to-back vectors
    runVec(32'hF00DBEEF, 0, '0, "R4");
    runVec(32'h0BADCAFE, 0, '0, "R4");

    // R10: reset during a run abandons it
    @(negedge clk);
    xIn   = 32'h55AA55AA;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(yValid == 1'b0 && done == 1'b0, "R10", "outputs in mid-run reset",
          {yValid, done}, 0);
    rstN = 1'b1;
    for (int c = 0; c < N + LAT + 3; c++) begin
      @(negedge clk);
      check(yValid == 1'b0, "R10", "no row after abandoned run", yValid, 0);
      check(done == 1'b0, "R10", "no done after abandoned run", done, 0);
    end
    runVec(32'h7F80017F, 0, '0, "R10");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule